// File: doc/BRIEF.md
# DMA Channel Register Front End with Aliased Layouts

This block holds the programming state of one DMA channel: a source pointer, a destination pointer, a transfer count and a small control word. Software reaches these four registers through a 64-byte window. The window is split into four groups of four word slots, and each group lists the same four registers in a different order. The last slot of every group is a start alias. A nonzero write to that slot updates its register and, if the channel is enabled, launches a transfer run. Software can therefore program any subset of registers and start the channel with a single burst of writes, whichever register it wants to write last.

The transfer engine sits beside the block. It reports each completed read and each completed write with a one-cycle strobe. The block advances the pointers by the element size, counts completed writes down, and drops `busy` when the run ends. The count is held twice: a stored length that software programs, and a live remaining count that each start loads from the stored length. The one exception is the count start alias, whose written value becomes the live count directly.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, every register reads 0, both pointer outputs are 0, `data_size` is 0 and `busy` is 0.
- R2: Slot decoding uses byte address bits [5:4] as the group and [3:2] as the position. Group 0 holds source, destination, count, control. Group 1 holds control, source, destination, count. Group 2 holds control, count, source, destination. Group 3 holds control, destination, count, source. A write through any alias is seen through every other alias of the same register. `data_size` reflects control bits [2:1].
- R3: A write whose byte address has bits [1:0] nonzero changes nothing, and a read at such an address returns 0.
- R4: A write to a count slot that is not a start alias sets only the stored length. While idle, every count alias reads the stored length.
- R5: A nonzero write to a start slot (0x0C, 0x1C, 0x2C, 0x3C) while enabled loads the live count and raises `busy` if that count is nonzero. The loaded value is the stored length for slots 0x0C, 0x2C and 0x3C. A zero write to a start slot only updates the register.
- R6: A start through 0x1C loads the written value into both the stored length and the live count in the same cycle.
- R7: A start write does nothing to `busy` or the live count when the enable bit (control bit 0) is clear. For the control slot 0x0C, the enable bit used is the one being written.
- R8: While busy, each `wr_done` lowers the live count by one, and `busy` falls on the strobe that takes the count from 1 to 0. While busy, every count alias reads the live count.
- R9: While busy, `rd_done` advances the source pointer and `wr_done` advances the destination pointer, each only if its increment bit is set (control bit 3 for source, bit 4 for destination). The step is 1, 2 or 4 bytes for size codes 00, 01 and 10; code 11 steps 4. Strobes have no effect while idle.
- R10: When a bus write and an engine strobe land in the same cycle, the bus write wins: a start overrides the count decrement, and a pointer write overrides the pointer advance.
- R11: The control read returns the enable bit, size and increment bits in bits [4:0], with `busy` in bit 31 and zeros elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte address within the 64-byte window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| rd_done | input | 1 | Engine completed one read |
| wr_done | input | 1 | Engine completed one write |
| cur_rd_addr | output | 32 | Next source address |
| cur_wr_addr | output | 32 | Next destination address |
| data_size | output | 2 | Element size code |
| busy | output | 1 | Channel run in progress |

## Verification
Two functions can fall in the same cycle: a software start or pointer rewrite, and a completion strobe from the engine that would otherwise decrement the count or advance the same pointer. The bench forces this with directed writes to 0x2C alongside `wr_done` and to 0x28 alongside `rd_done` in the middle of a run. Random cycles then mix bus writes with strobes at high rates. A bench model computes the outcome with the bus-write-wins rule, and every cycle the pointers, `busy` and a read of some slot are compared against it.

// File: rtl/dma_alias_pkg.sv
package dma_alias_pkg;

  typedef enum logic [1:0] {
    REG_SRC = 2'd0,
    REG_DST = 2'd1,
    REG_CNT = 2'd2,
    REG_CTL = 2'd3
  } reg_id_e;

  typedef struct packed {
    logic       inc_dst;
    logic       inc_src;
    logic [1:0] size;
    logic       en;
  } ctrl_t;

  localparam int CTRL_BITS = 5;
  localparam int BUSY_BIT  = 31;

  // Register held in a given position of a given alias group.
  function automatic reg_id_e slot_target(input logic [1:0] grp, input logic [1:0] pos);
    reg_id_e r;
    unique case (grp)
      2'd0: r = reg_id_e'(pos);
      2'd1: case (pos)
              2'd0: r = REG_CTL; 2'd1: r = REG_SRC; 2'd2: r = REG_DST; default: r = REG_CNT;
            endcase
      2'd2: case (pos)
              2'd0: r = REG_CTL; 2'd1: r = REG_CNT; 2'd2: r = REG_SRC; default: r = REG_DST;
            endcase
      default: case (pos)
              2'd0: r = REG_CTL; 2'd1: r = REG_DST; 2'd2: r = REG_CNT; default: r = REG_SRC;
            endcase
    endcase
    return r;
  endfunction

  // Byte step per element for a size code.
  function automatic logic [2:0] size_step(input logic [1:0] sz);
    case (sz)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dma_alias_decode.sv
module dma_alias_decode
  import dma_alias_pkg::*;
#(
  parameter int WIN_AW = 6
) (
  input  logic              we,
  input  logic [WIN_AW-1:0] addr,
  output logic              aligned,
  output reg_id_e           target,
  output logic              is_start_slot,
  output logic [3:0]        wr_sel
);
  always_comb begin
    aligned       = (addr[1:0] == 2'b00);
    target        = slot_target(addr[5:4], addr[3:2]);
    is_start_slot = (addr[3:2] == 2'd3);
    wr_sel        = (we && aligned) ? (4'b0001 << target) : 4'b0000;
  end
endmodule

// File: rtl/dma_addr_ptr.sv
module dma_addr_ptr #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          adv,
  input  logic [2:0]    step,
  output logic [AW-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= load_val;
    else if (adv)  ptr <= ptr + AW'(step);
  end

  // R10
  ptr_load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ptr == $past(load_val));
  // R9
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv) |=> $stable(ptr));
endmodule

// File: rtl/dma_xfer_counter.sv
module dma_xfer_counter #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reload_we,
  input  logic [CW-1:0] reload_val,
  input  logic          start,
  input  logic [CW-1:0] start_val,
  input  logic          dec,
  output logic [CW-1:0] reload_q,
  output logic [CW-1:0] live_q,
  output logic          busy_q,
  output logic          last_xfer
);
  logic dec_ok;
  assign dec_ok    = dec && busy_q;
  assign last_xfer = dec_ok && (live_q == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q <= '0;
      live_q   <= '0;
      busy_q   <= 1'b0;
    end else begin
      if (reload_we) reload_q <= reload_val;
      if (start) begin
        live_q <= start_val;
        busy_q <= (start_val != '0);
      end else if (dec_ok) begin
        live_q <= live_q - CW'(1);
        if (last_xfer) busy_q <= 1'b0;
      end
    end
  end

  // R8
  cnt_decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_ok && !start) |=> live_q == $past(live_q) - CW'(1));
  // R8
  busy_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(last_xfer) || $past(start)));
  // R10
  start_beats_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> live_q == $past(start_val));
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_alias_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [5:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          rd_done,
  input  logic          wr_done,
  output logic [AW-1:0] cur_rd_addr,
  output logic [AW-1:0] cur_wr_addr,
  output logic [1:0]    data_size,
  output logic          busy
);
  localparam int DW     = 32;
  localparam int N_PTRS = 2;

  logic       aligned, is_start_slot;
  reg_id_e    target;
  logic [3:0] wr_sel;

  dma_alias_decode #(.WIN_AW(6)) u_dec (
    .we(reg_we), .addr(reg_addr), .aligned(aligned),
    .target(target), .is_start_slot(is_start_slot), .wr_sel(wr_sel)
  );

  ctrl_t ctrl_q;
  always_ff @(posedge clk) begin
    if (!rst_n)               ctrl_q <= '0;
    else if (wr_sel[REG_CTL]) ctrl_q <= ctrl_t'(reg_wdata[CTRL_BITS-1:0]);
  end

  // Start decision: the enable used is the new one for a control-slot start.
  logic          en_eff, start_fire;
  logic [CW-1:0] start_val, reload_q, live_q;
  logic          busy_q, last_xfer;

  assign en_eff     = wr_sel[REG_CTL] ? reg_wdata[0] : ctrl_q.en;
  assign start_fire = (|wr_sel) && is_start_slot && (reg_wdata != '0) && en_eff;
  assign start_val  = (target == REG_CNT) ? reg_wdata[CW-1:0] : reload_q;

  dma_xfer_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .reload_we(wr_sel[REG_CNT]), .reload_val(reg_wdata[CW-1:0]),
    .start(start_fire), .start_val(start_val), .dec(wr_done),
    .reload_q(reload_q), .live_q(live_q), .busy_q(busy_q), .last_xfer(last_xfer)
  );

  // Pointers: index 0 is source, 1 is destination.
  logic [N_PTRS-1:0] p_load, p_adv;
  logic [AW-1:0]     p_val [N_PTRS];
  logic [2:0]        step;
  assign step      = size_step(ctrl_q.size);
  assign p_load[0] = wr_sel[REG_SRC];
  assign p_load[1] = wr_sel[REG_DST];
  assign p_adv[0]  = rd_done && busy_q && ctrl_q.inc_src;
  assign p_adv[1]  = wr_done && busy_q && ctrl_q.inc_dst;

  for (genvar i = 0; i < N_PTRS; i++) begin : g_ptr
    dma_addr_ptr #(.AW(AW)) u_ptr (
      .clk(clk), .rst_n(rst_n), .load(p_load[i]), .load_val(reg_wdata[AW-1:0]),
      .adv(p_adv[i]), .step(step), .ptr(p_val[i])
    );
  end

  assign cur_rd_addr = p_val[0];
  assign cur_wr_addr = p_val[1];
  assign data_size   = ctrl_q.size;
  assign busy        = busy_q;

  always_comb begin
    reg_rdata = '0;
    if (aligned) begin
      unique case (target)
        REG_SRC: reg_rdata = DW'(p_val[0]);
        REG_DST: reg_rdata = DW'(p_val[1]);
        REG_CNT: reg_rdata = DW'(busy_q ? live_q : reload_q);
        default: begin
          reg_rdata[CTRL_BITS-1:0] = ctrl_q;
          reg_rdata[BUSY_BIT]      = busy_q;
        end
      endcase
    end
  end

  // R5
  busy_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(start_fire));
  // R7
  no_start_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !en_eff && !busy_q) |=> !busy_q);
  // R3
  misaligned_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr[1:0] != 2'b00 && !busy_q) |=> $stable(ctrl_q) && $stable(reload_q));
endmodule

// File: tb/sim_dma_chan_regs.sv
module sim_dma_chan_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        rd_done = 1'b0, wr_done = 1'b0;
  logic [31:0] cur_rd_addr, cur_wr_addr;
  logic [1:0]  data_size;
  logic        busy;

  always #2 clk = ~clk;

  dma_chan_regs u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rd_done(rd_done),
    .wr_done(wr_done), .cur_rd_addr(cur_rd_addr), .cur_wr_addr(cur_wr_addr),
    .data_size(data_size), .busy(busy)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // Bench model state
  logic [31:0] m_src = 0, m_dst = 0, m_len = 0, m_live = 0;
  logic [4:0]  m_ctl = 0;
  logic        m_busy = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // 0 src, 1 dst, 2 count, 3 control; listed per slot index.
  function automatic int slot_of(input logic [3:0] s);
    case (s)
      4'h0: return 0; 4'h1: return 1; 4'h2: return 2; 4'h3: return 3;
      4'h4: return 3; 4'h5: return 0; 4'h6: return 1; 4'h7: return 2;
      4'h8: return 3; 4'h9: return 2; 4'hA: return 0; 4'hB: return 1;
      4'hC: return 3; 4'hD: return 1; 4'hE: return 2; default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] step_of(input logic [1:0] sz);
    return (sz == 2'b00) ? 32'd1 : (sz == 2'b01) ? 32'd2 : 32'd4;
  endfunction

  function automatic logic [31:0] model_read(input logic [5:0] a);
    if (a[1:0] != 0) return 0;
    case (slot_of(a[5:2]))
      0: return m_src;
      1: return m_dst;
      2: return m_busy ? m_live : m_len;
      default: return {m_busy, 26'd0, m_ctl};
    endcase
  endfunction

  function automatic string read_tag(input logic [5:0] a);
    if (a[1:0] != 0) return "R3";
    case (slot_of(a[5:2]))
      2: return "R4/R8";
      3: return "R11";
      default: return "R2";
    endcase
  endfunction

  task automatic step(input bit we, input logic [5:0] a, input logic [31:0] d,
                      input bit rdd, input bit wrd);
    logic [31:0] n_src, n_dst, n_len, n_live, sv;
    logic [4:0]  n_ctl;
    logic        n_busy, en;
    int          t;
    @(negedge clk);
    chk("R9 src", cur_rd_addr, m_src);
    chk("R9 dst", cur_wr_addr, m_dst);
    chk("R8 busy", {31'd0, busy}, {31'd0, m_busy});
    chk("R2 size", {30'd0, data_size}, {30'd0, m_ctl[2:1]});
    reg_we = we; reg_addr = a; reg_wdata = d; rd_done = rdd; wr_done = wrd;
    #1;
    chk(read_tag(a), reg_rdata, model_read(a));
    n_src = m_src; n_dst = m_dst; n_len = m_len; n_live = m_live;
    n_ctl = m_ctl; n_busy = m_busy;
    if (m_busy && rdd && m_ctl[3]) n_src = m_src + step_of(m_ctl[2:1]);
    if (m_busy && wrd && m_ctl[4]) n_dst = m_dst + step_of(m_ctl[2:1]);
    if (m_busy && wrd) begin
      n_live = m_live - 1;
      if (m_live == 1) n_busy = 0;
    end
    if (we && a[1:0] == 0) begin
      t = slot_of(a[5:2]);
      case (t)
        0: n_src = d;
        1: n_dst = d;
        2: n_len = d;
        default: n_ctl = d[4:0];
      endcase
      en = (t == 3) ? d[0] : m_ctl[0];
      if (a[3:2] == 2'd3 && d != 0 && en) begin
        sv = (t == 2) ? d : m_len;
        n_live = sv;
        n_busy = (sv != 0);
      end
    end
    @(posedge clk);
    m_src = n_src; m_dst = n_dst; m_len = n_len; m_live = n_live;
    m_ctl = n_ctl; m_busy = n_busy;
    #1;
    reg_we = 0; rd_done = 0; wr_done = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state through all sixteen slots
    for (int s = 0; s < 16; s++) step(0, 6'(s * 4), 0, 0, 0);
    chk("R1 busy", {31'd0, busy}, 0);
    chk("R1 src", cur_rd_addr, 0);
    // R2 alias writes, channel disabled
    step(1, 6'h0C, 0, 0, 0);
    step(1, 6'h14, 32'h1000, 0, 0);
    step(1, 6'h34, 32'h2000, 0, 0);
    step(1, 6'h2C, 32'h3000, 0, 0);
    chk("R7 dst trigger disabled", {31'd0, busy}, 0);
    chk("R2 dst alias", cur_wr_addr, 32'h3000);
    for (int s = 0; s < 16; s++) step(0, 6'(s * 4), 0, 0, 0);
    // R3 misaligned
    step(1, 6'h01, 32'hFFFF, 0, 0);
    chk("R3 write ignored", cur_rd_addr, 32'h1000);
    step(0, 6'h02, 0, 0, 0);
    chk("R3 read zero", reg_rdata, 0);
    // R4 stored length
    step(1, 6'h38, 5, 0, 0);
    step(0, 6'h24, 0, 0, 0);
    chk("R4 length readback", reg_rdata, 5);
    chk("R4 still idle", {31'd0, busy}, 0);
    // R7 control start with enable clear
    step(1, 6'h0C, 32'h18, 0, 0);
    chk("R7 ctl trigger disabled", {31'd0, busy}, 0);
    // R5 control start, word size, both increments
    step(1, 6'h0C, 32'h1D, 0, 0);
    chk("R5 started", {31'd0, busy}, 1);
    step(0, 6'h08, 0, 0, 0);
    chk("R5 live loaded", reg_rdata, 5);
    step(0, 6'h00, 0, 1, 1);
    chk("R9 src word step", cur_rd_addr, 32'h1004);
    chk("R9 dst word step", cur_wr_addr, 32'h3004);
    step(0, 6'h38, 0, 0, 0);
    chk("R8 live count", reg_rdata, 4);
    step(0, 6'h0C, 0, 0, 0);
    chk("R11 control read", reg_rdata, 32'h8000001D);
    // R10 collisions
    step(1, 6'h2C, 32'h5000, 0, 1);
    chk("R10 dst write wins", cur_wr_addr, 32'h5000);
    step(1, 6'h28, 32'h7000, 1, 0);
    chk("R10 src write wins", cur_rd_addr, 32'h7000);
    step(0, 6'h24, 0, 0, 0);
    chk("R10 restart beats decrement", reg_rdata, 5);
    // R6 direct count start
    step(1, 6'h1C, 2, 0, 0);
    step(0, 6'h00, 0, 0, 1);
    chk("R6 live from write", {31'd0, busy}, 1);
    step(0, 6'h00, 0, 0, 1);
    chk("R8 busy falls", {31'd0, busy}, 0);
    step(0, 6'h08, 0, 0, 0);
    chk("R6 length stored", reg_rdata, 2);
    // R9 halfword, then size 11 without increments
    step(1, 6'h0C, 32'h1B, 0, 0);
    step(0, 6'h00, 0, 1, 1);
    chk("R9 src half step", cur_rd_addr, 32'h7002);
    chk("R9 dst half step", cur_wr_addr, 32'h500A);
    step(1, 6'h10, 32'h07, 0, 0);
    step(0, 6'h00, 0, 1, 0);
    chk("R9 no increment", cur_rd_addr, 32'h7002);
    chk("R2 size code", {30'd0, data_size}, 3);
    // Random mix
    for (int i = 0; i < 4000; i++) begin
      logic [5:0]  a;
      logic [31:0] d;
      bit          we;
      we = ($urandom_range(0, 3) == 0);
      a  = {4'($urandom_range(0, 15)), 2'b00};
      if ($urandom_range(0, 15) == 0) a[1:0] = 2'($urandom_range(1, 3));
      case (slot_of(a[5:2]))
        2: d = $urandom_range(0, 6);
        3: d = {27'd0, 4'($urandom), ($urandom_range(0, 4) != 0)};
        default: d = $urandom;
      endcase
      if ($urandom_range(0, 9) == 0) d = 0;
      step(we, a, d, $urandom_range(0, 1) == 1, $urandom_range(0, 2) == 0);
    end
    step(0, 6'h00, 0, 0, 0);
    finish_run();
  end
endmodule